// File: doc/BRIEF.md
# Deferred-Reaction Self-Test Sequencer

This block drives a fixed set of built-in self-test engines one at a time and records whether each one passed. A single start pulse launches the chain. Each engine gets a one-cycle start strobe and answers with a done strobe and a fail flag. The next engine is launched only once the current one has answered or has gone silent for too long. Every failure, including a silent engine, sets that engine's bit in a sticky error register.

No reaction of any kind is taken while the chain runs. Once the last engine has finished, the block weighs the error register against a per-engine class register. Any failed engine marked unrecoverable causes a one-cycle destructive reset request. Any failed engine marked recoverable holds a fault line high until software clears its bit.

The error register sits on its own retention reset, so it keeps its contents through the destructive reset. The class register does not, so it returns to "all recoverable" and the retained bits then appear on the fault line as latched faults. Software can also set error bits directly. This exercises the whole reaction path without a real test failure.

Top module: `selftest_seq`

## Requirements
- R1: A `start` pulse sampled while `busy` is low raises `busy` and strobes `eng_start[0]` for one cycle in the next cycle. Engine i+1 is strobed in the cycle after engine i's done is sampled or its timeout expires. At most one strobe bit is ever high.
- R2: When `eng_done[i]` is sampled high for the active engine, error bit i is set if `eng_fail[i]` is 1 and left unchanged if it is 0.
- R3: If the active engine gives no done within TMO clock edges after the edge that strobed it, its error bit is set and the next engine is strobed.
- R4: While `busy` is high, `rst_req` and `flt_rec` stay low, whatever the error register holds.
- R5: A failure of any class does not stop the chain: every one of the N_ENG engines is strobed exactly once per run.
- R6: `rst_req` is high for exactly one cycle, in the cycle in which `busy` falls, when some error bit i is set with class bit i = 1 (1 = unrecoverable). `busy` falls in the cycle after the last engine ends.
- R7: `flt_rec` is high whenever `busy` is low and some error bit i is set with class bit i = 0. It stays high until that bit is cleared.
- R8: The register port has the following addresses:
  - Address 0 is the class register, read and write.
  - Address 1 reads the error register; a write clears the bits written as 1.
  - Address 2 reads the error register; a write sets the bits written as 1 (injection).
  - Address 3 reads `busy` in bit 0.
  An injection write while idle that sets a bit whose class is unrecoverable pulses `rst_req` in the next cycle.
- R9: Asserting `rst_n` leaves the error register unchanged and clears the class register to 0. Only `ret_rst_n` clears the error register.
- R10: A `start` pulse while `busy` is high is ignored: it launches no extra strobes and does not restart the chain.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low functional (destructive) reset |
| ret_rst_n | input | 1 | Active-low retention reset for the error register |
| start | input | 1 | Launch request for the test chain |
| eng_start | output | N_ENG | One-cycle start strobe per engine |
| eng_done | input | N_ENG | Done strobe per engine |
| eng_fail | input | N_ENG | Fail flag per engine, valid with done |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | N_ENG | Register write data |
| reg_rdata | output | N_ENG | Register read data (combinational) |
| busy | output | 1 | Chain running, reaction not yet issued |
| rst_req | output | 1 | Destructive reset request pulse |
| flt_rec | output | 1 | Recoverable fault level |

## Verification
The chain is run with random class masks, random fail flags and random answer delays. Some delays exceed the timeout window, so a single pattern mixes real fails, passes and silent engines, and the recorded bits show whether the fail flag and the timeout path are each honoured.

Directed runs cover three cases:
- All engines pass, which separates a silent reaction from a spurious one.
- Every engine is unrecoverable and the first one fails, which shows that the chain is not cut short.
- A late start pulse, which must not restart the chain.

Injection writes are applied in both classes to tell the reset path from the fault-line path. A functional reset with retained errors shows that the class register is wiped while the error bits survive.

// File: rtl/selftest_seq.sv
module selftest_seq #(
  parameter int N_ENG = 4,
  parameter int TMO   = 16,
  localparam int CW = $clog2(TMO + 1),
  localparam int IW = (N_ENG > 1) ? $clog2(N_ENG) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ret_rst_n,
  input  logic             start,
  output logic [N_ENG-1:0] eng_start,
  input  logic [N_ENG-1:0] eng_done,
  input  logic [N_ENG-1:0] eng_fail,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [N_ENG-1:0] reg_wdata,
  output logic [N_ENG-1:0] reg_rdata,
  output logic             busy,
  output logic             rst_req,
  output logic             flt_rec
);
  logic [N_ENG-1:0] cfg_q, err_q, err_d, strb_q, hit;
  logic [IW-1:0]    idx_q;
  logic [CW-1:0]    cnt_q;
  logic             busy_q, rq_q;

  wire done_now = busy_q && eng_done[idx_q];
  wire tmo_now  = busy_q && !eng_done[idx_q] && (cnt_q == CW'(TMO - 1));
  wire step     = done_now || tmo_now;
  wire last     = (idx_q == IW'(N_ENG - 1));
  wire wr_cfg   = reg_we && (reg_addr == 2'd0);
  wire wr_clr   = reg_we && (reg_addr == 2'd1);
  wire wr_inj   = reg_we && (reg_addr == 2'd2);

  always_comb begin
    hit = '0;
    if (step) hit[idx_q] = tmo_now | eng_fail[idx_q];
    err_d = (err_q & ~(wr_clr ? reg_wdata : '0)) | (wr_inj ? reg_wdata : '0) | hit;
  end

  always_ff @(posedge clk or negedge ret_rst_n)
    if (!ret_rst_n) err_q <= '0;
    else            err_q <= err_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q  <= '0;
      strb_q <= '0;
      idx_q  <= '0;
      cnt_q  <= '0;
      busy_q <= 1'b0;
      rq_q   <= 1'b0;
    end else begin
      strb_q <= '0;
      rq_q   <= 1'b0;
      if (wr_cfg) cfg_q <= reg_wdata;
      if (!busy_q) begin
        if (start) begin
          busy_q <= 1'b1;
          idx_q  <= '0;
          cnt_q  <= '0;
          strb_q <= N_ENG'(1);
        end else if (wr_inj) begin
          rq_q <= |(reg_wdata & cfg_q);
        end
      end else if (step) begin
        cnt_q <= '0;
        if (last) begin
          busy_q <= 1'b0;
          rq_q   <= |(err_d & cfg_q);
        end else begin
          idx_q  <= idx_q + 1'b1;
          strb_q <= N_ENG'(1) << (idx_q + 1'b1);
        end
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  always_comb begin
    case (reg_addr)
      2'd0:    reg_rdata = cfg_q;
      2'd3:    reg_rdata = N_ENG'(busy_q);
      default: reg_rdata = err_q;
    endcase
  end

  assign eng_start = strb_q;
  assign busy      = busy_q;
  assign rst_req   = rq_q;
  assign flt_rec   = !busy_q && |(err_q & ~cfg_q);
endmodule

module selftest_seq_chk #(
  parameter int N_ENG = 4,
  parameter int TMO   = 16,
  localparam int CW = $clog2(TMO + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             busy,
  input logic [N_ENG-1:0] eng_start,
  input logic             rst_req,
  input logic             flt_rec,
  input logic [CW-1:0]    cnt
);
  AST_START_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(eng_start)); // R1
  AST_FIRST_ENGINE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> eng_start[0]); // R1
  AST_IDLE_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> eng_start == '0); // R10
  AST_QUIET_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !rst_req && !flt_rec); // R4
  AST_TMO_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> cnt < CW'(TMO)); // R3
endmodule

bind selftest_seq selftest_seq_chk #(.N_ENG(N_ENG), .TMO(TMO)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy_q), .eng_start(strb_q),
  .rst_req(rq_q), .flt_rec(flt_rec), .cnt(cnt_q)
);

// File: tb/test_selftest_seq.sv
module test_selftest_seq;
  localparam int N = 4;
  localparam int TMO = 8;

  logic clk = 1'b0, rst_n = 1'b0, ret_rst_n = 1'b0, start = 1'b0;
  logic [N-1:0] eng_start, eng_done = '0, eng_fail = '0;
  logic reg_we = 1'b0;
  logic [1:0] reg_addr = 2'd0;
  logic [N-1:0] reg_wdata = '0, reg_rdata;
  logic busy, rst_req, flt_rec;

  int vecs = 0, bad = 0, pulses = 0;
  int dly[N];
  logic [N-1:0] fl;

  always #10 clk = ~clk;

  selftest_seq #(.N_ENG(N), .TMO(TMO)) i_selftest_seq (
    .clk(clk), .rst_n(rst_n), .ret_rst_n(ret_rst_n), .start(start),
    .eng_start(eng_start), .eng_done(eng_done), .eng_fail(eng_fail),
    .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .busy(busy), .rst_req(rst_req), .flt_rec(flt_rec));

  always @(negedge clk) if (eng_start != '0) pulses++;

  task automatic chk(input bit ok, input string r, input logic [31:0] act, input logic [31:0] exp);
    vecs++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  function automatic logic [N-1:0] exp_err();
    logic [N-1:0] e = '0;
    for (int i = 0; i < N; i++) e[i] = (dly[i] > TMO) ? 1'b1 : fl[i];
    return e;
  endfunction

  task automatic wr(input logic [1:0] a, input logic [N-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [N-1:0] d);
    reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic run_seq(input logic [N-1:0] cfg, input bit late_start);
    bit loud = 0;
    int p0, g;
    logic [N-1:0] e, r;
    logic exp_rq;
    wr(2'd1, '1);
    wr(2'd0, cfg);
    e = exp_err();
    exp_rq = |(e & cfg);
    p0 = pulses;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < N; i++) begin
      g = 0;
      while (eng_start !== N'(1 << i) && g < 100) begin
        if (rst_req || flt_rec) loud = 1;
        @(negedge clk); g++;
      end
      if (late_start && i == 1) start = 1'b1;
      if (dly[i] <= TMO) begin
        for (int k = 1; k < dly[i]; k++) begin
          if (rst_req || flt_rec) loud = 1;
          @(negedge clk); start = 1'b0;
        end
        eng_done[i] = 1'b1; eng_fail[i] = fl[i];
        @(negedge clk);
        start = 1'b0; eng_done = '0; eng_fail = '0;
      end
    end
    g = 0;
    while (busy && g < 100) begin
      if (rst_req || flt_rec) loud = 1;
      @(negedge clk); g++;
    end
    chk(!loud, "R4 quiet while busy", loud, 0);
    chk(pulses - p0 == N, "R5/R10 strobe count", pulses - p0, N);
    chk(rst_req == exp_rq, "R6 reset request at end", rst_req, exp_rq);
    rd(2'd1, r);
    chk(r == e, "R2/R3 error register", r, e);
    chk(flt_rec == |(e & ~cfg), "R7 recoverable fault", flt_rec, |(e & ~cfg));
    @(negedge clk);
    chk(rst_req == 1'b0, "R6 reset request one cycle", rst_req, 0);
    wr(2'd1, '1);
    chk(flt_rec == 1'b0, "R7 cleared by W1C", flt_rec, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    logic [N-1:0] r;
    void'($urandom(32'd13));
    repeat (2) @(negedge clk);
    rst_n = 1'b1; ret_rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !rst_req && !flt_rec && eng_start == '0, "R1 reset state",
        {busy, rst_req, flt_rec}, 0);

    // R1 directed: all pass, quick answers
    for (int i = 0; i < N; i++) dly[i] = 1;
    fl = '0;
    run_seq('1, 0);
    // R5: first engine fails, all unrecoverable, chain still completes
    for (int i = 0; i < N; i++) dly[i] = 2;
    fl = 4'b0001;
    run_seq('1, 0);
    // R3: last engine silent, recoverable
    for (int i = 0; i < N; i++) dly[i] = 3;
    dly[N-1] = TMO + 5;
    fl = '0;
    run_seq('0, 0);
    // R3 boundary: answer exactly at TMO is accepted
    for (int i = 0; i < N; i++) dly[i] = TMO;
    fl = 4'b0100;
    run_seq(4'b0100, 0);
    // R10: start while busy ignored
    for (int i = 0; i < N; i++) dly[i] = 4;
    fl = 4'b1000;
    run_seq(4'b0000, 1);

    for (int t = 0; t < 20; t++) begin
      for (int i = 0; i < N; i++) dly[i] = 1 + int'($urandom % (TMO + 2));
      fl = N'($urandom);
      run_seq(N'($urandom), 0);
    end

    // R8: injection of unrecoverable bit pulses reset
    wr(2'd0, 4'b0100);
    @(negedge clk); reg_we = 1'b1; reg_addr = 2'd2; reg_wdata = 4'b0100;
    @(negedge clk); reg_we = 1'b0;
    chk(rst_req == 1'b1, "R8 inject unrecoverable", rst_req, 1);
    chk(flt_rec == 1'b0, "R8 no recoverable fault", flt_rec, 0);
    @(negedge clk);
    chk(rst_req == 1'b0, "R8 pulse ends", rst_req, 0);
    wr(2'd2, 4'b0001);
    chk(flt_rec == 1'b1 && rst_req == 1'b0, "R8 inject recoverable", {flt_rec, rst_req}, 2'b10);
    rd(2'd2, r);
    chk(r == 4'b0101, "R8 error readback", r, 4'b0101);
    rd(2'd3, r);
    chk(r == '0, "R8 busy readback", r, 0);

    // R9: functional reset keeps errors, wipes class
    wr(2'd0, 4'b1111);
    chk(flt_rec == 1'b0, "R9 all unrecoverable masks line", flt_rec, 0);
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    rd(2'd1, r);
    chk(r == 4'b0101, "R9 errors retained", r, 4'b0101);
    rd(2'd0, r);
    chk(r == '0, "R9 class cleared", r, 0);
    chk(flt_rec == 1'b1, "R9 latched fault shown", flt_rec, 1);
    @(negedge clk); ret_rst_n = 1'b0;
    @(negedge clk); ret_rst_n = 1'b1;
    rd(2'd1, r);
    chk(r == '0, "R9 retention reset clears", r, 0);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule